// File: doc/BRIEF.md
# Synchronized Multi-Channel Clock Divider Bank

This block takes one fast input clock and produces four derived clocks from it. Each channel has its own settings:
- an integer divide ratio from 1 to 1024;
- a bypass, in which the channel passes the input clock through undivided;
- a coarse phase delay, counted in whole input-clock cycles;
- an output pair that is either differential (complementary) or two in-phase single-ended copies.

Software loads the settings through a small parallel write port. The settings are kept in staging registers.

A shared active-low sync input parks every channel at a static level for as long as it is held low. The first clock edge that samples sync high again is the common alignment edge. At that edge each channel takes its staged settings and restarts, so all outputs keep a fixed, known phase relation. Writes made while the channels run therefore never disturb a running waveform.

An active-low asynchronous reset does three things: it returns every setting to its default, silences all outputs while it is asserted, and after release the bank aligns by itself at the first edge that samples sync high.

Top module: `clkdiv_bank`

## Requirements
- R1: While rst_n is low, every outP and outN bit is 0. After release, each channel holds its defaults: ratio code 1, phase 0, not bypassed, differential.
- R2: A write with wrEn high stores wrData into the staging register selected by wrAddr. wrAddr[3:2] selects the channel and wrAddr[1:0] the field:
  - field 0: ratio code, taken from wrData[9:0];
  - field 1: phase, taken from wrData[9:0];
  - field 2: mode, with wrData[0] as bypass and wrData[1] as single-ended;
  - field 3: the write is ignored.
- R3: A ratio code k from 2 to 1023 gives an output period of k input cycles. Code 0 gives a period of 1024 input cycles.
- R4: In each period of N cycles the divided output is high for floor(N/2) cycles and low for the rest.
- R5: When a channel is bypassed, or its ratio code is 1, its outP follows clk while the channel runs.
- R6: From the first edge that samples sync_n low, every outP is 0. Each outN is then 1 if its channel is differential and 0 if it is single-ended, and they stay that way while sync_n stays low.
- R7: Let edge E be the first edge that samples sync_n high after it was low, and let P be a channel's phase.
  - A divided channel's outP is low after edges E+1 to E+P.
  - After edge E+k, for k > P, outP is high exactly when (k-1-P) mod N < floor(N/2).
- R8: Settings written while the channels run change no output until the next alignment edge. They take effect at that edge.
- R9: Once out of reset, a differential channel drives outN = ~outP and a single-ended channel drives outN = outP.
- R10: After reset release, the first edge that samples sync_n high acts as an alignment edge with no sync pulse needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; all channels derive from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low hold; its rising edge realigns all channels |
| wrEn | input | 1 | Write strobe for the staging registers |
| wrAddr | input | 4 | Channel in [3:2], field in [1:0] |
| wrData | input | 10 | Write data |
| outP | output | 4 | True output of each channel |
| outN | output | 4 | Companion output: complement or in-phase copy |

## Verification
The assertions assume the following about the inputs:
- sync_n and the write port change away from the rising clock edge, so each edge samples one settled value;
- phase values are smaller than the ratio, as the usage intends.

The stimulus meets these assumptions as follows:
- it drives every input on the falling edge, or a quarter period after the rising edge;
- it only programs phases from 0 to N-1;
- it writes while the channels run only to show that the write has no effect until the next release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int RATIO_W = 10;

  localparam logic [1:0] FLD_RATIO = 2'd0;
  localparam logic [1:0] FLD_PHASE = 2'd1;
  localparam logic [1:0] FLD_MODE  = 2'd2;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] phase;
    logic               bypass;
    logic               singleEnded;
  } chanCfg_t;

  typedef struct packed {
    logic hold;
    logic load;
  } syncStrb_t;

  localparam chanCfg_t CFG_DEFAULT = '{
    ratio: RATIO_W'(1),
    phase: '0,
    bypass: 1'b0,
    singleEnded: 1'b0
  };
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_n,
  input  logic                     wrEn,
  input  logic [CH_W+1:0]          wrAddr,
  input  logic [RATIO_W-1:0]       wrData,
  output chanCfg_t [NUM_CH-1:0]    cfgShadow,
  output syncStrb_t                strb
);
  logic syncQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= 1'b0;
    else        syncQ <= sync_n;
  end

  assign strb.hold = ~sync_n;
  assign strb.load = sync_n & ~syncQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_shadow
    logic hit;
    assign hit = wrEn && (wrAddr[CH_W+1:2] == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgShadow[i] <= CFG_DEFAULT;
      end else if (hit) begin
        case (wrAddr[1:0])
          FLD_RATIO: cfgShadow[i].ratio <= wrData;
          FLD_PHASE: cfgShadow[i].phase <= wrData;
          FLD_MODE: begin
            cfgShadow[i].bypass      <= wrData[0];
            cfgShadow[i].singleEnded <= wrData[1];
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> !strb.load);
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  syncStrb_t strb,
  input  chanCfg_t  cfgIn,
  input  logic      live,
  output logic      outP,
  output logic      outN
);
  chanCfg_t           act;
  logic               runQ;
  logic               q;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] waitCnt;
  logic [RATIO_W:0]   nVal;
  logic [RATIO_W:0]   highLen;
  logic [RATIO_W-1:0] lastIdx;
  logic               bypassEff;

  assign nVal      = (act.ratio == '0) ? {1'b1, {RATIO_W{1'b0}}} : {1'b0, act.ratio};
  assign highLen   = nVal >> 1;
  assign lastIdx   = nVal[RATIO_W-1:0] - RATIO_W'(1);
  assign bypassEff = act.bypass | (act.ratio == RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= CFG_DEFAULT;
      runQ    <= 1'b0;
      q       <= 1'b0;
      cnt     <= '0;
      waitCnt <= '0;
    end else if (strb.hold) begin
      runQ <= 1'b0;
      q    <= 1'b0;
    end else if (strb.load) begin
      act     <= cfgIn;
      runQ    <= 1'b1;
      q       <= 1'b0;
      cnt     <= '0;
      waitCnt <= cfgIn.phase;
    end else if (runQ) begin
      if (waitCnt != '0) begin
        waitCnt <= waitCnt - RATIO_W'(1);
        q       <= 1'b0;
      end else begin
        q   <= ({1'b0, cnt} < highLen);
        cnt <= (cnt == lastIdx) ? '0 : cnt + RATIO_W'(1);
      end
    end
  end

  assign outP = bypassEff ? (clk & runQ) : q;
  assign outN = !live ? 1'b0 : (act.singleEnded ? outP : ~outP);

  // R6
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> (!q && !runQ));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runQ |-> ({1'b0, cnt} < nVal));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(act));

  // R7
  phase_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !strb.hold && !strb.load && waitCnt != '0) |=> !q);
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  syncStrb_t             strb,
  input  chanCfg_t [NUM_CH-1:0] cfgShadow,
  output logic [NUM_CH-1:0]     outP,
  output logic [NUM_CH-1:0]     outN
);
  logic liveQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) liveQ <= 1'b0;
    else        liveQ <= 1'b1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    clkdiv_chan chan_i (
      .clk   (clk),
      .rst_n (rst_n),
      .strb  (strb),
      .cfgIn (cfgShadow[i]),
      .live  (liveQ),
      .outP  (outP[i]),
      .outN  (outN[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [RATIO_W-1:0] wrData,
  output logic [NUM_CH-1:0]  outP,
  output logic [NUM_CH-1:0]  outN
);
  chanCfg_t [NUM_CH-1:0] cfgShadow;
  syncStrb_t             strb;

  clkdiv_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .cfgShadow (cfgShadow),
    .strb      (strb)
  );

  clkdiv_datapath #(.NUM_CH(NUM_CH)) datapath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .cfgShadow (cfgShadow),
    .outP      (outP),
    .outN      (outN)
  );
endmodule

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_n;
  logic       wrEn;
  logic [3:0] wrAddr;
  logic [9:0] wrData;
  logic [3:0] outP;
  logic [3:0] outN;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  clkdiv_bank dut_i (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .outP(outP), .outN(outN)
  );

  // per vector: {code, phase} for channels 0..3; expected N equals code
  localparam int VEC[3][8] = '{
    '{2, 0, 3, 0, 4, 1, 5, 2},
    '{7, 3, 6, 5, 10, 0, 3, 2},
    '{9, 8, 8, 7, 2, 1, 16, 15}
  };

  function automatic bit expQ(int k, int n, int p);
    if (k - 1 < p) return 1'b0;
    return ((k - 1 - p) % n) < (n / 2);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int fld, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'((ch << 2) | fld); wrData = 10'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic holdSync();
    @(negedge clk); sync_n = 1'b0;
    @(posedge clk);
  endtask

  task automatic releaseSync();
    @(negedge clk); sync_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int mism [4];
    int firstAct [4];
    int firstExp [4];
    int bad;
    rst_n = 1'b0; sync_n = 1'b1; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    #5;
    // R1 outputs silent in reset
    check(outP == 4'h0 && outN == 4'h0, "R1 reset outputs", {outP, outN}, 0);

    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    // R10 auto alignment, R5 default ratio 1 follows clk, R9 differential
    check(outP == 4'hF, "R10 auto align high phase", outP, 15);
    check(outN == 4'h0, "R9 differential high phase", outN, 0);
    #10;
    check(outP == 4'h0, "R5 default ratio1 low phase", outP, 0);
    check(outN == 4'hF, "R9 differential low phase", outN, 15);

    // vector table: R3, R4, R7
    for (int v = 0; v < 3; v++) begin
      holdSync();
      for (int ch = 0; ch < 4; ch++) begin
        wr(ch, 0, VEC[v][2*ch]);
        wr(ch, 1, VEC[v][2*ch+1]);
        wr(ch, 2, 0);
      end
      releaseSync();
      for (int ch = 0; ch < 4; ch++) mism[ch] = 0;
      for (int k = 1; k <= 48; k++) begin
        @(posedge clk); #5;
        for (int ch = 0; ch < 4; ch++) begin
          bit e;
          e = expQ(k, VEC[v][2*ch], VEC[v][2*ch+1]);
          if (outP[ch] != e) begin
            if (mism[ch] == 0) begin firstAct[ch] = outP[ch]; firstExp[ch] = e; end
            mism[ch]++;
          end
        end
      end
      for (int ch = 0; ch < 4; ch++)
        check(mism[ch] == 0, "R3 R4 R7 divided waveform", firstAct[ch], firstExp[ch]);
    end

    // R3 code 0 = divide by 1024
    holdSync();
    wr(0, 0, 0); wr(0, 1, 0);
    releaseSync();
    for (int k = 1; k <= 1025; k++) begin
      @(posedge clk); #5;
      if (k == 1 || k == 512 || k == 1025)
        check(outP[0] == 1'b1, "R3 code0 high", outP[0], 1);
      if (k == 513 || k == 1024)
        check(outP[0] == 1'b0, "R3 code0 low", outP[0], 0);
    end

    // R5 bypass
    holdSync();
    wr(1, 0, 5); wr(1, 2, 1);
    releaseSync();
    @(posedge clk); #5;
    check(outP[1] == 1'b1, "R5 bypass high phase", outP[1], 1);
    #10;
    check(outP[1] == 1'b0, "R5 bypass low phase", outP[1], 0);

    // R6 hold parks outputs
    @(negedge clk); sync_n = 1'b0;
    @(posedge clk); #5;
    check(outP == 4'h0, "R6 hold outP", outP, 0);
    check(outN == 4'hF, "R6 hold outN differential", outN, 15);
    repeat (3) @(posedge clk);
    #5;
    check(outP == 4'h0 && outN == 4'hF, "R6 hold static", {outP, outN}, 8'h0F);

    // R9 single-ended pair
    wr(1, 2, 0);
    wr(3, 0, 3); wr(3, 1, 0); wr(3, 2, 2);
    wr(2, 0, 4); wr(2, 1, 0);
    releaseSync();
    bad = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #5;
      if (outN[3] != outP[3] || outN[2] != ~outP[2] || outP[3] != expQ(k, 3, 0)) bad++;
    end
    check(bad == 0, "R9 single-ended and differential pairs", bad, 0);
    holdSync();
    check(outN[3] == 1'b0 && outN[2] == 1'b1, "R6 hold outN by mode", {outN[3], outN[2]}, 1);

    // R8 write while running has no effect until the next release
    wr(2, 0, 4); wr(2, 1, 0);
    releaseSync();
    bad = 0;
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); #5;
      if (outP[2] != expQ(k, 4, 0)) bad++;
      if (k == 4) begin wrEn = 1'b1; wrAddr = 4'((2 << 2) | 0); wrData = 10'd6; end
      if (k == 5) wrEn = 1'b0;
    end
    check(bad == 0, "R8 running waveform kept", bad, 0);
    holdSync();
    releaseSync();
    bad = 0;
    for (int k = 1; k <= 24; k++) begin
      @(posedge clk); #5;
      if (outP[2] != expQ(k, 6, 0)) bad++;
    end
    check(bad == 0, "R8 new ratio after release", bad, 0);

    // R2 field 3 ignored; other channels unaffected
    holdSync();
    wr(0, 0, 0); wr(0, 1, 0); wr(0, 2, 0);
    wr(0, 3, 10'h3FF);
    wr(1, 0, 7); wr(1, 1, 0);
    releaseSync();
    bad = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #5;
      if (outP[0] != 1'b1 || outP[1] != expQ(k, 7, 0)) bad++;
      #10;
      if (outP[0] != 1'b1) bad++;
    end
    check(bad == 0, "R2 field3 ignored and channel select", bad, 0);

    // R1 mid-run reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #5;
    check(outP == 4'h0 && outN == 4'h0, "R1 reset mid-run", {outP, outN}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check(outP == 4'hF && outN == 4'h0, "R1 defaults high phase", {outP, outN}, 8'hF0);
    #10;
    check(outP == 4'h0 && outN == 4'hF, "R1 defaults low phase", {outP, outN}, 8'h0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule